// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Sub-Source Layer

This block gathers up to 32 main interrupt lines and 11 secondary lines into one IRQ request for a CPU. Each main line sets a bit in a source-pending register whether or not it is masked. A main mask register decides which pending bits may compete. When the single-winner register is empty, the lowest-index eligible source is moved into it as a one-hot value, and its index is published in an index register. The IRQ output stays high for as long as the winner register holds a bit. Software reads the index, clears the source-pending bit and the winner bit by writing ones, and repeats until the IRQ drops.

The 11 secondary lines have their own pending and mask registers. The unmasked pending secondary bits are ORed in four groups. Each group drives one main source line, so one main source can stand for several secondary causes. Access is through a small word-addressed register bus. Writes take effect at the clock edge, and reads are combinational.

Top module: `irqc_cascade`

## Requirements
- R1: After reset: source-pending = 0, winner = 0, index = 0, main mask = all ones, secondary mask = 0x7FF, IRQ low.
- R2: A main line that is high at a clock edge sets its source-pending bit at that edge, whatever its mask bit.
- R3: Writing to source-pending (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every bit.
- R4: When a line is high at the same edge as a clear write to its own bit, the bit stays set.
- R5: A source whose main mask bit (address 1) is 1 is never moved into the winner register. Once its mask bit is written to 0, it becomes eligible.
- R6: At an edge where the winner register is empty, the lowest-index bit of source-pending AND NOT mask is loaded as a one-hot value. Its index is loaded into the index register (address 3, bits 4:0). At most one winner bit is ever set.
- R7: The winner register (address 2) is write-one-to-clear. Zeros written have no effect. After it empties, the next eligible source is loaded one edge later.
- R8: The IRQ output is high exactly while the winner register is non-zero.
- R9: A secondary line that is high at an edge sets its bit in secondary-pending (address 4). That register is write-one-to-clear. The secondary mask (address 5) is read/write, and a 1 blocks the line.
- R10: Secondary bits 0-2 feed main source 28, bits 3-5 feed 23, bits 6-8 feed 15, and bits 9-10 feed 31. Each feed is the OR of that group's pending, unmasked secondary bits. A masked secondary bit feeds nothing.
- R11: Reads of an address outside 0-5 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Main interrupt lines, active high |
| sub_i | input | 11 | Secondary interrupt lines, active high |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: 32 main sources, 11 secondary lines, and the four group targets at 28, 23, 15 and 31. With these values, one run can drive all four cascade groups into their main sources. It can also race secondary feeds against direct lines for the lowest-index choice, and hit the top source index 31 as a group target.

// File: rtl/irqc_pkg.sv
// Package: shared register addresses and the secondary-group mapping.
// Assumes exactly four secondary groups, three lines each except the last.
package irqc_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int NUM_GRP = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_SRCPEND = 3'd0,
        A_MAINMSK = 3'd1,
        A_WINNER  = 3'd2,
        A_INDEX   = 3'd3,
        A_SUBPEND = 3'd4,
        A_SUBMSK  = 3'd5
    } reg_addr_e;

    // Group that a secondary line belongs to: three lines per group, last group takes the rest.
    function automatic int sub_group(input int idx);
        int g;
        g = idx / 3;
        if (g > NUM_GRP - 1) g = NUM_GRP - 1;
        return g;
    endfunction

endpackage

// File: rtl/irqc_regif.sv
// Register interface: turns bus writes into per-register strobes and
// clear vectors, and builds the combinational read data.
// Assumes one write per cycle and that bus_we is a single-cycle strobe.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 11,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_SRC-1:0] srcpend_clr,
    output logic               mainmsk_we,
    output logic [NUM_SRC-1:0] winner_clr,
    output logic [NUM_SUB-1:0] subpend_clr,
    output logic               submsk_we,
    input  logic [NUM_SRC-1:0] srcpend_q,
    input  logic [NUM_SRC-1:0] mainmsk_q,
    input  logic [NUM_SRC-1:0] winner_q,
    input  logic [IDX_W-1:0]   index_q,
    input  logic [NUM_SUB-1:0] subpend_q,
    input  logic [NUM_SUB-1:0] submsk_q
);

    // Write decode: a clear vector is the write data when addressed, else zero.
    always_comb begin
        srcpend_clr = '0;
        winner_clr  = '0;
        subpend_clr = '0;
        mainmsk_we  = 1'b0;
        submsk_we   = 1'b0;
        if (bus_we) begin
            unique case (bus_addr)
                A_SRCPEND: srcpend_clr = bus_wdata[NUM_SRC-1:0];
                A_MAINMSK: mainmsk_we  = 1'b1;
                A_WINNER:  winner_clr  = bus_wdata[NUM_SRC-1:0];
                A_SUBPEND: subpend_clr = bus_wdata[NUM_SUB-1:0];
                A_SUBMSK:  submsk_we   = 1'b1;
                default:   ;
            endcase
        end
    end

    // Read mux: zero-extended register view, zero for unmapped addresses.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SRCPEND: bus_rdata[NUM_SRC-1:0] = srcpend_q;
            A_MAINMSK: bus_rdata[NUM_SRC-1:0] = mainmsk_q;
            A_WINNER:  bus_rdata[NUM_SRC-1:0] = winner_q;
            A_INDEX:   bus_rdata[IDX_W-1:0]   = index_q;
            A_SUBPEND: bus_rdata[NUM_SUB-1:0] = subpend_q;
            A_SUBMSK:  bus_rdata[NUM_SUB-1:0] = submsk_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_sub_cascade.sv
// Secondary layer: latches secondary lines, applies their mask and ORs the
// live bits of each group onto that group's main source position.
// Assumes group target indices are distinct and below NUM_SRC.
module irqc_sub_cascade
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_SUB   = 11,
    parameter int GRP0_MAIN = 28,
    parameter int GRP1_MAIN = 23,
    parameter int GRP2_MAIN = 15,
    parameter int GRP3_MAIN = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUB-1:0] sub_i,
    input  logic [NUM_SUB-1:0] subpend_clr,
    input  logic               submsk_we,
    input  logic [NUM_SUB-1:0] submsk_wdata,
    output logic [NUM_SUB-1:0] subpend_q,
    output logic [NUM_SUB-1:0] submsk_q,
    output logic [NUM_SRC-1:0] feed_o
);

    localparam int GRP_MAIN [NUM_GRP] = '{GRP0_MAIN, GRP1_MAIN, GRP2_MAIN, GRP3_MAIN};

    logic [NUM_SUB-1:0] live;
    logic [NUM_GRP-1:0] grp_hit;

    // Secondary pending: set by line, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) subpend_q <= '0;
        else        subpend_q <= (subpend_q & ~subpend_clr) | sub_i;
    end

    // Secondary mask: all lines blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         submsk_q <= '1;
        else if (submsk_we) submsk_q <= submsk_wdata;
    end

    assign live = subpend_q & ~submsk_q;

    // One OR reduction per group over the lines that belong to it.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [NUM_SUB-1:0] sel;
        always_comb begin
            for (int i = 0; i < NUM_SUB; i++) sel[i] = (sub_group(i) == g);
        end
        assign grp_hit[g] = |(live & sel);
    end

    // Place each group result on its main source position.
    always_comb begin
        feed_o = '0;
        for (int g = 0; g < NUM_GRP; g++) feed_o[GRP_MAIN[g]] = grp_hit[g];
    end

    // R9: a pending bit not cleared stays set.
    p_subpend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(subpend_q) & ~$past(subpend_clr)) & ~subpend_q) == '0));

    // R9: a line high at an edge is pending after it.
    p_subpend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(sub_i)) & ~subpend_q) == '0));

endmodule

// File: rtl/irqc_main_pend.sv
// Main pending stage: latches main lines (direct or cascaded) into
// source-pending and holds the main mask. Exposes eligible candidates.
// Assumes the cascaded feed is already merged into line_i.
module irqc_main_pend #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic [NUM_SRC-1:0] srcpend_clr,
    input  logic               mainmsk_we,
    input  logic [NUM_SRC-1:0] mainmsk_wdata,
    output logic [NUM_SRC-1:0] srcpend_q,
    output logic [NUM_SRC-1:0] mainmsk_q,
    output logic [NUM_SRC-1:0] cand_o
);

    // Source pending: line sets, write-one clears, set wins the tie.
    always_ff @(posedge clk) begin
        if (!rst_n) srcpend_q <= '0;
        else        srcpend_q <= (srcpend_q & ~srcpend_clr) | line_i;
    end

    // Main mask: every source blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          mainmsk_q <= '1;
        else if (mainmsk_we) mainmsk_q <= mainmsk_wdata;
    end

    assign cand_o = srcpend_q & ~mainmsk_q;

    // R2: a high line is latched regardless of mask.
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(line_i) & ~srcpend_q) == '0));

    // R3: bits not written as one survive the write.
    p_w1c_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(srcpend_q) & ~$past(srcpend_clr)) & ~srcpend_q) == '0));

endmodule

// File: rtl/irqc_arbiter.sv
// Winner stage: when empty, loads the lowest-index candidate as a one-hot
// value with its index; otherwise applies write-one clears.
// Assumes NUM_SRC is at least 2.
module irqc_arbiter #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cand_i,
    input  logic [NUM_SRC-1:0] winner_clr,
    output logic [NUM_SRC-1:0] winner_q,
    output logic [IDX_W-1:0]   index_q,
    output logic               irq_o
);

    logic             found;
    logic [IDX_W-1:0] low_idx;

    // Priority search: first set candidate bit from index 0 upward.
    always_comb begin
        found   = 1'b0;
        low_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && cand_i[i]) begin
                found   = 1'b1;
                low_idx = IDX_W'(i);
            end
        end
    end

    // Winner and index update: promote when empty, clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            winner_q <= '0;
            index_q  <= '0;
        end else if (winner_q == '0) begin
            if (found) begin
                winner_q <= NUM_SRC'(1) << low_idx;
                index_q  <= low_idx;
            end
        end else if ((winner_q & ~winner_clr) == '0) begin
            winner_q <= '0;
            index_q  <= '0;
        end
    end

    assign irq_o = (winner_q != '0);

    // R6: never more than one winner bit.
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(winner_q));

    // R6: the index names the set winner bit.
    p_index_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (winner_q != '0) |-> winner_q[index_q]);

    // R6: a promotion picks the lowest candidate of the previous cycle.
    p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(winner_q) == '0 && $past(cand_i) != '0) |->
        (winner_q == ($past(cand_i) & (~$past(cand_i) + NUM_SRC'(1)))));

    // R7: a held winner without a clear is stable.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(winner_q) != '0 && ($past(winner_q) & $past(winner_clr)) == '0)
        |-> (winner_q == $past(winner_q)));

endmodule

// File: rtl/irqc_cascade.sv
// Top: cascaded interrupt controller. Secondary groups are ORed into main
// lines, main lines latch into source-pending, one winner drives irq_o.
// Assumes NUM_SRC <= 32 (bus width) and group targets below NUM_SRC.
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_SUB   = 11,
    parameter int GRP0_MAIN = 28,
    parameter int GRP1_MAIN = 23,
    parameter int GRP2_MAIN = 15,
    parameter int GRP3_MAIN = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SUB-1:0] sub_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] srcpend_clr, winner_clr, srcpend_q, mainmsk_q, winner_q, cand, feed;
    logic [NUM_SUB-1:0] subpend_clr, subpend_q, submsk_q;
    logic               mainmsk_we, submsk_we;
    logic [IDX_W-1:0]   index_q;

    irqc_regif #(.NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB)) u_regif (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .srcpend_clr(srcpend_clr), .mainmsk_we(mainmsk_we), .winner_clr(winner_clr),
        .subpend_clr(subpend_clr), .submsk_we(submsk_we),
        .srcpend_q(srcpend_q), .mainmsk_q(mainmsk_q), .winner_q(winner_q),
        .index_q(index_q), .subpend_q(subpend_q), .submsk_q(submsk_q)
    );

    irqc_sub_cascade #(
        .NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB),
        .GRP0_MAIN(GRP0_MAIN), .GRP1_MAIN(GRP1_MAIN),
        .GRP2_MAIN(GRP2_MAIN), .GRP3_MAIN(GRP3_MAIN)
    ) u_sub (
        .clk(clk), .rst_n(rst_n), .sub_i(sub_i), .subpend_clr(subpend_clr),
        .submsk_we(submsk_we), .submsk_wdata(bus_wdata[NUM_SUB-1:0]),
        .subpend_q(subpend_q), .submsk_q(submsk_q), .feed_o(feed)
    );

    irqc_main_pend #(.NUM_SRC(NUM_SRC)) u_main (
        .clk(clk), .rst_n(rst_n), .line_i(src_i | feed), .srcpend_clr(srcpend_clr),
        .mainmsk_we(mainmsk_we), .mainmsk_wdata(bus_wdata[NUM_SRC-1:0]),
        .srcpend_q(srcpend_q), .mainmsk_q(mainmsk_q), .cand_o(cand)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .cand_i(cand), .winner_clr(winner_clr),
        .winner_q(winner_q), .index_q(index_q), .irq_o(irq_o)
    );

    // R5: a masked source never becomes the winner.
    p_masked_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(winner_q) == '0) |-> ((winner_q & $past(mainmsk_q)) == '0));

    // R8: the request line follows the winner register.
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (winner_q != '0));

    // R10: a live secondary bit in group 1 reaches its main source.
    p_feed_grp1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|($past(subpend_q[5:3]) & ~$past(submsk_q[5:3]))) |-> srcpend_q[GRP1_MAIN]));

endmodule

// File: tb/irqc_cascade_tb_top.sv
// Directed bench for irqc_cascade: one task per scenario, each self-checking.
module irqc_cascade_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [10:0] sub_i = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqc_cascade dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .sub_i(sub_i),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Write lands at the posedge between the two negedges.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1", "srcpend", v, 32'h0);
        rd(3'd1, v); chk("R1", "mainmsk", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1", "winner", v, 32'h0);
        rd(3'd3, v); chk("R1", "index", v, 32'h0);
        rd(3'd5, v); chk("R1", "submsk", v, 32'h7FF);
        chk("R1", "irq", {31'h0, irq_o}, 32'h0);
        rd(3'd7, v); chk("R11", "unmapped read", v, 32'h0);
    endtask

    task automatic t_masked_latch();
        logic [31:0] v;
        src_i[5] = 1'b1; step(); src_i[5] = 1'b0; step();
        rd(3'd0, v); chk("R2", "masked line latched", v, 32'h20);
        rd(3'd2, v); chk("R5", "masked not promoted", v, 32'h0);
        chk("R8", "irq low when empty", {31'h0, irq_o}, 32'h0);
        wr(3'd1, ~32'h20);
        step();
        rd(3'd2, v); chk("R5", "promoted after unmask", v, 32'h20);
        rd(3'd3, v); chk("R6", "index 5", v, 32'd5);
        chk("R8", "irq high", {31'h0, irq_o}, 32'h1);
        wr(3'd0, 32'h20);
        wr(3'd2, 32'h0);
        rd(3'd2, v); chk("R7", "zero write no effect", v, 32'h20);
        wr(3'd2, 32'h20);
        rd(3'd2, v); chk("R7", "winner cleared", v, 32'h0);
        chk("R8", "irq drops", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        src_i = (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20);
        step(); src_i = '0; step();
        rd(3'd3, v); chk("R6", "lowest first", v, 32'd3);
        rd(3'd2, v); chk("R6", "one-hot 3", v, 32'h8);
        wr(3'd0, 32'h8);
        rd(3'd0, v); chk("R3", "zeros keep others", v, (32'h1 << 9) | (32'h1 << 20));
        wr(3'd2, 32'h8);
        step();
        rd(3'd3, v); chk("R7", "next winner 9", v, 32'd9);
        wr(3'd0, 32'h200); wr(3'd2, 32'h200);
        step();
        rd(3'd3, v); chk("R7", "next winner 20", v, 32'd20);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R3", "all ones clears", v, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R7", "all ones clears winner", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        src_i[7] = 1'b1;
        wr(3'd0, 32'h80);
        rd(3'd0, v); chk("R4", "set beats clear", v, 32'h80);
        src_i[7] = 1'b0;
        wr(3'd0, 32'h80); wr(3'd2, 32'h80);
        rd(3'd0, v); chk("R3", "cleared after release", v, 32'h0);
        chk("R8", "irq low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_sub();
        logic [31:0] v;
        sub_i[4] = 1'b1; step(); sub_i[4] = 1'b0; step();
        rd(3'd4, v); chk("R9", "sub pending latched", v, 32'h10);
        rd(3'd0, v); chk("R10", "masked sub no feed", v, 32'h0);
        wr(3'd5, 32'h7FF & ~32'h10);
        rd(3'd5, v); chk("R9", "submsk readback", v, 32'h7EF);
        step();
        rd(3'd0, v); chk("R10", "group 3-5 to 23", v, 32'h1 << 23);
        step();
        rd(3'd3, v); chk("R10", "index 23", v, 32'd23);
        wr(3'd4, 32'h10);
        rd(3'd4, v); chk("R9", "sub w1c", v, 32'h0);
        wr(3'd0, 32'h1 << 23); wr(3'd2, 32'h1 << 23);
        chk("R8", "irq low after sub", {31'h0, irq_o}, 32'h0);
        wr(3'd5, 32'h0);
        sub_i = 11'h481; step(); sub_i = '0; step();
        rd(3'd0, v); chk("R10", "groups to 15 28 31", v, (32'h1 << 15) | (32'h1 << 28) | (32'h1 << 31));
        step();
        rd(3'd3, v); chk("R6", "cascaded lowest 15", v, 32'd15);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_masked_latch();
        t_priority();
        t_set_wins();
        t_sub();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule